// File: doc/BRIEF.md
# Cipher Subkey Schedule Generator

This block turns a 128-bit cipher key into the 52 sixteen-bit subkeys used by an eight-round block cipher. Each round uses six subkeys and a closing half-round uses four. The key is held as eight 16-bit words. Each later group of eight words comes from the previous group turned left by 25 bit positions across the whole 128 bits. In hardware, that rotation is done as a fixed bit-field mapping from the words of one group to the words of the next.

A one-cycle start request latches the key, provided the block is not already streaming. The block then presents one subkey per clock with a valid strobe and its index, from 0 to 51, so a memory can write the stream to consecutive addresses. After the last subkey, valid drops and a done flag rises. The flag holds until the next accepted start.

Top module: `keysched_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, sk_valid_o and done_o are 0 and sk_index_o is 0.
- R2: A start_i sampled high on a clock edge while no stream is running latches key_i. In the following cycle sk_valid_o is 1 and sk_index_o is 0.
- R3: While streaming, exactly one subkey is presented per clock and sk_index_o rises by one each cycle. sk_valid_o stays high for exactly 52 consecutive cycles, indices 0 to 51.
- R4: Subkeys 0 to 7 are the key's 16-bit words, and subkey 0 is key_i[127:112]. Subkey n (n<8) is key_i[127-16n : 112-16n].
- R5: For each later group, word i has bits [15:9] equal to bits [6:0] of word (i+1) mod 8 of the previous group, and bits [8:0] equal to bits [15:7] of word (i+2) mod 8. This is the same as rotating the whole 128-bit group left by 25.
- R6: On the clock edge after index 51 is presented, sk_valid_o falls and done_o rises. done_o stays high until the next accepted start.
- R7: start_i and key_i have no effect while a stream is running. The subkeys, the indices and the stream length are unchanged.
- R8: A start accepted while done_o is high clears done_o and begins a fresh stream from index 0 with the new key.
- R9: sk_index_o never exceeds 51 while valid, and sk_valid_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to latch key_i and start a schedule |
| key_i | input | 128 | Cipher key; bits [127:112] are word 0 |
| sk_valid_o | output | 1 | Subkey on sk_data_o is valid |
| sk_index_o | output | 6 | Index of the presented subkey, 0 to 51 |
| sk_data_o | output | 16 | Subkey value |
| done_o | output | 1 | Schedule finished; held until the next accepted start |

## Verification
The assertions take for granted that key_i is meaningful only on the edge where a start is accepted. The first-word property compares subkey 0 with the key seen on that edge, not with any later value. They also take for granted that a start arriving mid-stream must leave no trace. That is checked through the internal load event, which must never fire while valid is high. The stimulus changes inputs only at falling edges. It holds key_i steady around each accepted start, and it deliberately raises start_i with a different key in the middle of a stream, so the load must stay idle there. Reset is applied both from idle and in the middle of a stream.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int KS_WORD_W = 16;
  localparam int KS_WORDS  = 8;
  localparam int KS_ROT    = 25;
  localparam int KS_TOTAL  = 52;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_RUN  = 2'd1,
    KS_DONE = 2'd2
  } ks_state_e;
endpackage

// File: rtl/ks_group_reg.sv
module ks_group_reg #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int ROT    = 25,
  localparam int KEY_W = WORD_W * WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic                         adv_i,
  input  logic [KEY_W-1:0]             key_i,
  output logic [WORDS-1:0][WORD_W-1:0] words_o
);
  localparam int SKIP = (ROT / WORD_W) % WORDS;
  localparam int BSH  = ROT % WORD_W;

  typedef logic [WORDS-1:0][WORD_W-1:0] grp_t;

  // Word 0 is the most significant slice of the key.
  function automatic grp_t split_key(input logic [KEY_W-1:0] k);
    grp_t g;
    for (int i = 0; i < WORDS; i++)
      g[i] = k[KEY_W-1-i*WORD_W -: WORD_W];
    return g;
  endfunction

  // Group-wide left rotation by ROT bits expressed per word.
  function automatic grp_t next_group(input grp_t p);
    grp_t n;
    for (int i = 0; i < WORDS; i++) begin
      logic [WORD_W-1:0] hi_src;
      logic [WORD_W-1:0] lo_src;
      hi_src = p[(i + SKIP) % WORDS];
      lo_src = p[(i + SKIP + 1) % WORDS];
      n[i] = WORD_W'((hi_src << BSH) | (lo_src >> (WORD_W - BSH)));
    end
    return n;
  endfunction

  grp_t grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      grp_q <= '0;
    else if (load_i)
      grp_q <= split_key(key_i);
    else if (adv_i)
      grp_q <= next_group(grp_q);
  end

  assign words_o = grp_q;
endmodule

// File: rtl/ks_sequencer.sv
module ks_sequencer
  import ks_pkg::*;
#(
  parameter int TOTAL = 52,
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             last_o
);
  ks_state_e        st_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o = (st_q == KS_RUN);
  assign done_o = (st_q == KS_DONE);
  assign load_o = start_i && !busy_o;
  assign last_o = busy_o && (idx_q == IDX_W'(TOTAL - 1));
  assign adv_o  = busy_o && !last_o && (idx_q[SEL_W-1:0] == SEL_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      idx_q <= '0;
    end else if (load_o) begin
      st_q  <= KS_RUN;
      idx_q <= '0;
    end else if (last_o) begin
      st_q  <= KS_DONE;
      idx_q <= '0;
    end else if (busy_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/ks_word_sel.sv
module ks_word_sel #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic [WORDS-1:0][WORD_W-1:0] words_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [WORD_W-1:0]            word_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < WORDS; i++)
      if (sel_i == SEL_W'(i)) word_o = words_i[i];
  end
endmodule

// File: rtl/keysched_gen.sv
module keysched_gen
  import ks_pkg::*;
#(
  parameter int WORD_W = KS_WORD_W,
  parameter int WORDS  = KS_WORDS,
  parameter int ROT    = KS_ROT,
  parameter int TOTAL  = KS_TOTAL,
  localparam int KEY_W = WORD_W * WORDS,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              sk_valid_o,
  output logic [IDX_W-1:0]  sk_index_o,
  output logic [WORD_W-1:0] sk_data_o,
  output logic              done_o
);
  logic                         busy_w;
  logic                         load_evt;
  logic                         adv_evt;
  logic                         last_evt;
  logic [IDX_W-1:0]             idx_w;
  logic [WORDS-1:0][WORD_W-1:0] words_w;

  ks_sequencer #(.TOTAL(TOTAL), .WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_w), .done_o(done_o), .idx_o(idx_w),
    .load_o(load_evt), .adv_o(adv_evt), .last_o(last_evt)
  );

  ks_group_reg #(.WORD_W(WORD_W), .WORDS(WORDS), .ROT(ROT)) u_grp (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .adv_i(adv_evt),
    .key_i(key_i), .words_o(words_w)
  );

  ks_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_sel (
    .words_i(words_w), .sel_i(idx_w[SEL_W-1:0]), .word_o(sk_data_o)
  );

  assign sk_valid_o = busy_w;
  assign sk_index_o = idx_w;
endmodule

// File: rtl/keysched_chk.sv
module keysched_chk #(
  parameter int WORD_W = 16,
  parameter int KEY_W  = 128,
  parameter int IDX_W  = 6,
  parameter int TOTAL  = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [KEY_W-1:0]  key_i,
  input logic              sk_valid_o,
  input logic [IDX_W-1:0]  sk_index_o,
  input logic [WORD_W-1:0] sk_data_o,
  input logic              done_o,
  input logic              load_evt
);
  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sk_valid_o |-> (sk_index_o <= IDX_W'(TOTAL - 1)));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sk_valid_o && done_o));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_valid_o && sk_index_o != IDX_W'(TOTAL - 1)) |=>
      (sk_valid_o && sk_index_o == $past(sk_index_o) + 1'b1));

  assert_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_valid_o && sk_index_o == IDX_W'(TOTAL - 1)) |=> (!sk_valid_o && done_o));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sk_valid_o && start_i) |=> (sk_valid_o && sk_index_o == '0 && !done_o));

  assert_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sk_valid_o && start_i) |=> (sk_data_o == $past(key_i[KEY_W-1 -: WORD_W])));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sk_valid_o |-> !load_evt);
endmodule

bind keysched_gen keysched_chk #(
  .WORD_W(WORD_W), .KEY_W(KEY_W), .IDX_W(IDX_W), .TOTAL(TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
  .sk_valid_o(sk_valid_o), .sk_index_o(sk_index_o), .sk_data_o(sk_data_o),
  .done_o(done_o), .load_evt(load_evt)
);

// File: tb/keysched_gen_tb.sv
module keysched_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         sk_valid_o;
  logic [5:0]   sk_index_o;
  logic [15:0]  sk_data_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  keysched_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .sk_valid_o(sk_valid_o), .sk_index_o(sk_index_o),
    .sk_data_o(sk_data_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [127:0] key;
    logic [5:0]   idx;
    logic [15:0]  exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{128'h0001_0002_0003_0004_0005_0006_0007_0008, 6'd8,  16'h0400},
    '{128'h0001_0002_0003_0004_0005_0006_0007_0008, 6'd15, 16'h0200},
    '{128'h0001_0002_0003_0004_0005_0006_0007_0008, 6'd3,  16'h0004},
    '{{128{1'b1}},                                   6'd51, 16'hFFFF},
    '{128'h8000_0000_0000_0000_0000_0000_0000_0000, 6'd14, 16'h0100},
    '{128'h8000_0000_0000_0000_0000_0000_0000_0000, 6'd0,  16'h8000}
  };

  // Model: plain 128-bit rotation, one per completed group.
  function automatic logic [15:0] model(input logic [127:0] k, input int n);
    logic [127:0] r;
    r = k;
    for (int g = 0; g < n / 8; g++) r = {r[102:0], r[127:103]};
    r = r >> (112 - 16 * (n % 8));
    return r[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs a full stream from an idle or done state; optional mid-stream start.
  task automatic run_stream(input logic [127:0] k, input int pick,
                            input logic [15:0] pick_exp, input bit poke);
    @(negedge clk);
    key_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R8", "done cleared on start", done_o, 0);
    for (int n = 0; n < 52; n++) begin
      check(sk_valid_o == 1'b1, "R3", "valid during stream", sk_valid_o, 1);
      check(sk_index_o == 6'(n) && !done_o, "R9", "index ascending", sk_index_o, n);
      check(sk_data_o == model(k, n), (n < 8) ? "R4" : "R5", "subkey value",
            sk_data_o, model(k, n));
      if (n == pick)
        check(sk_data_o == pick_exp, "R5", "table value", sk_data_o, pick_exp);
      if (poke && n == 20) begin start_i = 1'b1; key_i = ~k; end
      if (poke && n == 21) begin start_i = 1'b0; key_i = k; end
      @(negedge clk);
    end
    check(sk_valid_o == 1'b0, "R3", "valid after 52", sk_valid_o, 0);
    check(done_o == 1'b1, "R6", "done after last", done_o, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sk_valid_o && !done_o && sk_index_o == 0, "R1", "in reset",
          {sk_valid_o, done_o, sk_index_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sk_valid_o && !done_o && sk_index_o == 0, "R1", "after reset",
          {sk_valid_o, done_o, sk_index_o}, 0);

    foreach (VECS[v]) run_stream(VECS[v].key, VECS[v].idx, VECS[v].exp, 1'b0);

    // R7: start with a different key mid-stream must not disturb the stream.
    run_stream(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 60, 16'h0, 1'b1);

    // R6: done holds without start.
    repeat (5) @(negedge clk);
    check(done_o == 1'b1 && !sk_valid_o, "R6", "done held", done_o, 1);

    // R8: restart directly from done (first subkey word 0 of new key).
    run_stream(128'hA5A5_1234_0F0F_F0F0_DEAD_BEEF_CAFE_0001, 0, 16'hA5A5, 1'b0);

    // R1: reset in the middle of a stream.
    @(negedge clk);
    key_i = 128'h1111_2222_3333_4444_5555_6666_7777_8888; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!sk_valid_o && !done_o && sk_index_o == 0, "R1", "mid-stream reset",
          {sk_valid_o, done_o, sk_index_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!sk_valid_o && !done_o, "R1", "idle after reset", {sk_valid_o, done_o}, 0);

    // R2: single-cycle start from idle gives index 0 next cycle.
    key_i = 128'hBEEF_0000_0000_0000_0000_0000_0000_0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(sk_valid_o && sk_index_o == 0 && sk_data_o == 16'hBEEF, "R2",
          "first cycle after start", sk_data_o, 16'hBEEF);
    repeat (60) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule